// File: doc/BRIEF.md
# Backup Over-Limit and Heartbeat Abort Unit

This unit is a hardware backstop for a coil-current protection chain. An upstream analog stage multiplies two coil currents and compares the product against a fixed force limit. It hands this unit a single digital over-limit bit. The control program separately toggles a heartbeat bit to show that it is still running. The unit runs without help from any software path. It requests a controlled shutdown, which drives all coil currents to zero, in either of two cases: the over-limit bit stays high without a single break for a persistence window (3 ms, which is 3000 cycles of a 1 MHz clock), or the heartbeat shows no edge for a timeout window (2 ms by default).

Both asynchronous inputs pass through two-flop synchronizers before anything evaluates them. The abort request is sticky. A two-bit cause output records which source tripped it, and both bits can end up set. The request can be cleared only while the unit is disarmed. While the unit is disarmed, neither source can trip it.

Top module: `abort_backstop`

## Requirements
- R1: After reset, abort_o is 0 and cause_o is 2'b00.
- R2: While armed, if over_lim_i is high on PERSIST_CYC consecutive synchronized cycles, abort_o rises and cause_o bit 0 (persistence cause) is set. Count the first rising edge at which over_lim_i is sampled high as edge 1. The outputs change at edge PERSIST_CYC+2.
- R3: A single synchronized low cycle of over_lim_i restarts the persistence count from zero. High runs shorter than PERSIST_CYC never cause an abort.
- R4: Both rising and falling heartbeat edges count as activity. Each synchronized edge restarts the watchdog count. A heartbeat whose edges arrive less than WDOG_CYC cycles apart keeps abort_o low.
- R5: While armed, if no heartbeat edge arrives for WDOG_CYC cycles, abort_o rises and cause_o bit 1 (watchdog cause) is set. With a steady heartbeat, count the first rising edge at which arm_i is 1 as edge 1. The outputs change at edge WDOG_CYC.
- R6: While arm_i is 0, neither an over-limit level nor a stopped heartbeat sets abort_o or any cause bit. Both counters are held at zero.
- R7: Once set, abort_o and its cause bits stay set after the over-limit bit falls or the heartbeat resumes.
- R8: When clear_i is high at a rising edge while arm_i is 0, abort_o and cause_o return to 0 at that edge. When clear_i is high while arm_i is 1, it has no effect.
- R9: Cause bits accumulate. A second source that trips while an abort is already latched adds its own bit, so cause_o can read 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Unit clock (1 MHz with the default windows) |
| rst_n | input | 1 | Active-low asynchronous reset |
| over_lim_i | input | 1 | Asynchronous current-product-over-limit bit from the comparator |
| beat_i | input | 1 | Asynchronous heartbeat bit toggled by the control program |
| arm_i | input | 1 | Synchronous arm control; 1 enables both monitors |
| clear_i | input | 1 | Synchronous abort clear, honoured only while disarmed |
| abort_o | output | 1 | Latched controlled-shutdown request |
| cause_o | output | 2 | Latched cause: bit 0 persistence, bit 1 watchdog |

## Verification
The bench builds the unit with PERSIST_CYC = 8 and WDOG_CYC = 12, so that both windows expire in a few dozen cycles. With these values the exact trip edge of each source can be checked one cycle either side of the boundary. High runs of PERSIST_CYC-1 cycles separated by a single low cycle probe the restart behaviour. A heartbeat that toggles every 8 cycles has edges of one polarity 16 cycles apart, which is longer than the 12-cycle timeout. It therefore keeps the watchdog quiet only if falling edges count as activity as well as rising ones.

// File: rtl/abort_backstop_pkg.sv
package abort_backstop_pkg;
    localparam int CAUSE_W       = 2;
    localparam int CAUSE_PERSIST = 0;
    localparam int CAUSE_WDOG    = 1;
    localparam int SYNC_W        = 2;
    localparam int SYNC_OVER     = 0;
    localparam int SYNC_BEAT     = 1;

    typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/bs_sync2.sv
module bs_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/bs_persist.sv
module bs_persist #(
    parameter int CYC = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic lvl_i,
    output logic fire_o
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic fire;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (!en_i || !lvl_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            fire = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire_o = fire;

    // R3: a dropout leaves no way to fire on the next cycle
    a_r3_dropout_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_i |=> !fire_o);
    // R6: disarmed means no trip in the following cycle
    a_r6_persist_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (st_q.cnt == '0));
endmodule

// File: rtl/bs_beat_wdog.sv
module bs_beat_wdog #(
    parameter int CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic beat_i,
    output logic fire_o
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic edge_seen;
    logic fire;

    always_comb begin
        st_d      = st_q;
        fire      = 1'b0;
        edge_seen = beat_i ^ st_q.prev;
        st_d.prev = beat_i;
        if (!en_i || edge_seen) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            fire = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire_o = fire;

    // R4: a heartbeat edge keeps the watchdog from firing next cycle
    a_r4_edge_feeds: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_i != $past(beat_i)) |=> !fire_o);
endmodule

// File: rtl/abort_backstop.sv
module abort_backstop
    import abort_backstop_pkg::*;
#(
    parameter int PERSIST_CYC = 3000,
    parameter int WDOG_CYC    = 2000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               over_lim_i,
    input  logic               beat_i,
    input  logic               arm_i,
    input  logic               clear_i,
    output logic               abort_o,
    output logic [CAUSE_W-1:0] cause_o
);
    typedef struct packed {
        cause_t cause;
    } st_t;

    st_t               st_d, st_q;
    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] syn;
    logic              trip_p;
    logic              trip_w;
    logic              do_clear;

    assign raw_in[SYNC_OVER] = over_lim_i;
    assign raw_in[SYNC_BEAT] = beat_i;

    bs_sync2 #(.W(SYNC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn)
    );

    bs_persist #(.CYC(PERSIST_CYC)) u_persist (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (arm_i),
        .lvl_i  (syn[SYNC_OVER]),
        .fire_o (trip_p)
    );

    bs_beat_wdog #(.CYC(WDOG_CYC)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (arm_i),
        .beat_i (syn[SYNC_BEAT]),
        .fire_o (trip_w)
    );

    always_comb begin
        st_d     = st_q;
        do_clear = clear_i && !arm_i;
        if (do_clear) begin
            st_d.cause = '0;
        end else begin
            if (trip_p) st_d.cause[CAUSE_PERSIST] = 1'b1;
            if (trip_w) st_d.cause[CAUSE_WDOG]    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_o = st_q.cause;
    assign abort_o = |st_q.cause;

    // R2: a persistence trip is recorded as cause bit 0
    a_r2_persist_cause: assert property (@(posedge clk) disable iff (!rst_n)
        trip_p |=> (abort_o && cause_o[CAUSE_PERSIST]));
    // R5: a watchdog trip is recorded as cause bit 1
    a_r5_wdog_cause: assert property (@(posedge clk) disable iff (!rst_n)
        trip_w |=> (abort_o && cause_o[CAUSE_WDOG]));
    // R7: a latched cause only goes away through a disarmed clear
    a_r7_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_o[CAUSE_PERSIST] && !(clear_i && !arm_i)) |=> cause_o[CAUSE_PERSIST]);
    // R8: clear while armed does not drop the request
    a_r8_no_clear_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && abort_o) |=> abort_o);
    // R6: disarmed and idle stays idle
    a_r6_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i && !abort_o) |=> !abort_o);
endmodule

// File: tb/sim_abort_backstop.sv
module sim_abort_backstop;
    localparam int P = 8;
    localparam int W = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       over_lim_i = 1'b0;
    logic       beat_i = 1'b0;
    logic       arm_i = 1'b0;
    logic       clear_i = 1'b0;
    logic       abort_o;
    logic [1:0] cause_o;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    bit    feed_on = 1'b0;
    bit [2:0] q_exp[$];
    string    q_tag[$];

    always #2 clk = ~clk;

    abort_backstop #(.PERSIST_CYC(P), .WDOG_CYC(W)) u0 (
        .clk(clk), .rst_n(rst_n), .over_lim_i(over_lim_i), .beat_i(beat_i),
        .arm_i(arm_i), .clear_i(clear_i), .abort_o(abort_o), .cause_o(cause_o)
    );

    // heartbeat feeder: an edge every 8 cycles, alternating polarity
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            if (feed_on) begin
                k++;
                if (k == 8) begin
                    beat_i = ~beat_i;
                    k = 0;
                end
            end else begin
                k = 0;
            end
        end
    end

    // monitor: pop expected items and compare with outputs
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_exp.size() > 0) begin
                bit [2:0] e;
                string    t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                n_chk++;
                if ({abort_o, cause_o} !== e) begin
                    n_bad++;
                    $display("FAIL %s: got abort=%0b cause=%b, expected abort=%0b cause=%b",
                             t, abort_o, cause_o, e[2], e[1:0]);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input bit ab, input bit [1:0] ca, input string tag);
        q_exp.push_back({ab, ca});
        q_tag.push_back(tag);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, got timeout, expected completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        expect_now(1'b0, 2'b00, "R1 reset state");

        // R6: disarmed, over-limit held and heartbeat stopped
        over_lim_i = 1'b1;
        step(3 * W);
        expect_now(1'b0, 2'b00, "R6 disarmed ignores both sources");
        over_lim_i = 1'b0;

        // R4: armed with a both-edge heartbeat every 8 cycles
        feed_on = 1'b1;
        step(2);
        arm_i = 1'b1;
        step(4 * W);
        expect_now(1'b0, 2'b00, "R4 both-edge heartbeat keeps watchdog quiet");

        // R3: runs of P-1 high separated by one low cycle
        for (int r = 0; r < 4; r++) begin
            over_lim_i = 1'b1;
            step(P - 1);
            over_lim_i = 1'b0;
            step(1);
        end
        step(6);
        expect_now(1'b0, 2'b00, "R3 interrupted runs never abort");

        // R2: continuous over-limit, exact trip edge
        over_lim_i = 1'b1;
        step(P + 1);
        expect_now(1'b0, 2'b00, "R2 not yet tripped one edge early");
        step(1);
        expect_now(1'b1, 2'b01, "R2 persistence trip at edge P+2");
        over_lim_i = 1'b0;
        step(10);
        expect_now(1'b1, 2'b01, "R7 abort stays latched after dropout");

        // R8: clear while armed has no effect
        feed_on = 1'b0;
        clear_i = 1'b1;
        step(1);
        clear_i = 1'b0;
        step(1);
        expect_now(1'b1, 2'b01, "R8 clear ignored while armed");
        arm_i = 1'b0;
        clear_i = 1'b1;
        step(1);
        clear_i = 1'b0;
        step(1);
        expect_now(1'b0, 2'b00, "R8 clear honoured while disarmed");
        step(4);

        // R5: armed with stopped heartbeat
        arm_i = 1'b1;
        step(W - 1);
        expect_now(1'b0, 2'b00, "R5 not yet tripped one edge early");
        step(2);
        expect_now(1'b1, 2'b10, "R5 watchdog trip");

        // R9: persistence added on top of the watchdog cause
        over_lim_i = 1'b1;
        step(P + 4);
        expect_now(1'b1, 2'b11, "R9 both cause bits accumulate");
        over_lim_i = 1'b0;
        feed_on = 1'b1;
        step(20);
        expect_now(1'b1, 2'b11, "R7 latched after heartbeat resumes");

        // clear and idle while disarmed
        arm_i = 1'b0;
        feed_on = 1'b0;
        clear_i = 1'b1;
        step(1);
        clear_i = 1'b0;
        step(1);
        expect_now(1'b0, 2'b00, "R8 second disarmed clear");
        step(3 * W);
        expect_now(1'b0, 2'b00, "R6 stopped heartbeat ignored when disarmed");

        step(2);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule